// File: doc/BRIEF.md
# Set-Associative Cache Miss Classifier

This block models only the tags of a two-way set-associative cache with least-recently-used replacement. It watches a stream of memory block numbers, one per clock while a valid strobe is high. It sorts each access into one of three kinds: a hit, a compulsory miss (the block has not been referenced since reset or the last clear), or a conflict miss (the block was referenced earlier but other blocks of the same set have since pushed it out).

A history bitmap with one bit per possible block number records every block ever referenced. This bitmap separates first-touch misses from misses caused by set contention. The verdict appears one clock after the access. Three saturating counters keep running totals of the three kinds. A one-cycle synchronous clear returns the cache, the history bitmap and the counters to their empty state. The block is meant for analysing access traces and for studying replacement behaviour in hardware.

Top module: `miss_classifier`

## Requirements
- R1: After reset, and in the cycle after a clear, every counter reads 0 and `cls_valid` is low. Every block then counts as never referenced, so its next accepted access reports code 01.
- R2: With default parameters there are 128 sets of 2 ways each. The set index is bits [6:0] of the block number and the tag is bits [8:7], so blocks whose numbers differ by a multiple of 128 compete for the same set.
- R3: An access to a block that is present in its set reports code 00 (hit).
- R4: A miss on a block that has not been referenced since reset or the last clear reports code 01 (compulsory), even when it evicts a valid block from a full set.
- R5: A miss on a block that was referenced earlier but is no longer present reports code 10 (conflict). Code 11 is never produced.
- R6: A miss fills an empty way (way 0 before way 1) before it evicts anything. In a full set the least recently used way is replaced, and both hits and fills make the accessed way most recently used.
- R7: `cls_valid` is high in exactly the cycle after an accepted access (`acc_valid` high and `clr` low), and `cls_code` holds that access's code in that cycle.
- R8: `cnt_hit`, `cnt_comp` and `cnt_conf` each rise by one for the matching code, and the new value is visible in the same cycle as `cls_valid`. At most one counter changes per cycle.
- R9: Each counter is 16 bits wide and stays at 65535 instead of wrapping.
- R10: `clr` takes priority over an access in the same cycle. Such an access is not classified, not counted and not recorded as referenced.
- R11: The 16-access pattern 0,128,256,128,0,128,256,128,1,129,257,129,1,129,257,129, repeated 10 times from empty, ends with 78 hits, 6 compulsory misses and 76 conflict misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of cache, history and counters |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_blk | input | 9 | Block number of the access |
| cls_valid | output | 1 | Classification valid (one cycle after the access) |
| cls_code | output | 2 | 00 hit, 01 compulsory miss, 10 conflict miss |
| cnt_hit | output | 16 | Saturating hit total |
| cnt_comp | output | 16 | Saturating compulsory-miss total |
| cnt_conf | output | 16 | Saturating conflict-miss total |

## Verification
A wrong tag, valid bit or LRU bit stays hidden until the same set is accessed again. It then shows up as a swapped hit/conflict code in the cycle after that access, so the sweeps revisit every set with tags chosen to exercise each replacement decision. A stuck or missing history bit turns a compulsory code into a conflict code, or the reverse, on the first touch of that block. A full forward sweep of the block space after a clear exposes this at once. Counter faults appear in the same cycle as the access's verdict, and long runs of one block drive the hit counter to its ceiling.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [1:0] {
        CLS_HIT  = 2'b00,
        CLS_COMP = 2'b01,
        CLS_CONF = 2'b10
    } cls_e;

    typedef struct packed {
        logic vld;
        cls_e code;
    } verdict_s;

endpackage

// File: rtl/mc_tag_store.sv
module mc_tag_store #(
    parameter int SET_W = 7,
    parameter int TAG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             look_en,
    input  logic [SET_W-1:0] look_set,
    input  logic [TAG_W-1:0] look_tag,
    output logic             look_hit
);
    localparam int NUM_SETS = 1 << SET_W;

    logic [1:0]       vld_q [NUM_SETS];
    logic [1:0]       vld_d [NUM_SETS];
    logic [TAG_W-1:0] tag_q [NUM_SETS][2];
    logic [TAG_W-1:0] tag_d [NUM_SETS][2];
    logic [NUM_SETS-1:0] lru_q, lru_d;

    logic hit_w0, hit_w1, victim;

    always_comb begin
        vld_d = vld_q;
        tag_d = tag_q;
        lru_d = lru_q;
        hit_w0 = vld_q[look_set][0] && (tag_q[look_set][0] == look_tag);
        hit_w1 = vld_q[look_set][1] && (tag_q[look_set][1] == look_tag);
        victim = 1'b0;
        if (!vld_q[look_set][0])      victim = 1'b0;
        else if (!vld_q[look_set][1]) victim = 1'b1;
        else                          victim = lru_q[look_set];

        if (clr) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                vld_d[s] = 2'b00;
            end
            lru_d = '0;
        end else if (look_en) begin
            if (hit_w0) begin
                lru_d[look_set] = 1'b1;
            end else if (hit_w1) begin
                lru_d[look_set] = 1'b0;
            end else begin
                vld_d[look_set][victim] = 1'b1;
                tag_d[look_set][victim] = look_tag;
                lru_d[look_set]         = ~victim;
            end
        end
    end

    assign look_hit = hit_w0 | hit_w1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                vld_q[s]    <= 2'b00;
                tag_q[s][0] <= '0;
                tag_q[s][1] <= '0;
            end
            lru_q <= '0;
        end else begin
            vld_q <= vld_d;
            tag_q <= tag_d;
            lru_q <= lru_d;
        end
    end

endmodule

// File: rtl/mc_seen_map.sv
module mc_seen_map #(
    parameter int BLK_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             mark_en,
    input  logic [BLK_W-1:0] blk,
    output logic             seen
);
    localparam int NUM_BLKS = 1 << BLK_W;

    logic [NUM_BLKS-1:0] seen_q, seen_d;

    always_comb begin
        seen_d = seen_q;
        if (clr)          seen_d = '0;
        else if (mark_en) seen_d[blk] = 1'b1;
    end

    assign seen = seen_q[blk];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= seen_d;
    end

endmodule

// File: rtl/mc_sat_counter.sv
module mc_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                     cnt_d = '0;
        else if (inc && ~&cnt_q)     cnt_d = cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/miss_classifier.sv
module miss_classifier #(
    parameter int BLK_W = 9,
    parameter int SET_W = 7,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             acc_valid,
    input  logic [BLK_W-1:0] acc_blk,
    output logic             cls_valid,
    output logic [1:0]       cls_code,
    output logic [CNT_W-1:0] cnt_hit,
    output logic [CNT_W-1:0] cnt_comp,
    output logic [CNT_W-1:0] cnt_conf
);
    import mc_pkg::*;

    localparam int TAG_W  = BLK_W - SET_W;
    localparam int N_KIND = 3;

    logic             take;
    logic             hit, seen;
    logic [SET_W-1:0] set_idx;
    logic [TAG_W-1:0] tag;
    cls_e             code;
    logic [N_KIND-1:0] inc_vec;
    logic [CNT_W-1:0]  cnt_arr [N_KIND];
    verdict_s          out_d, out_q;

    assign set_idx = acc_blk[SET_W-1:0];
    assign tag     = acc_blk[BLK_W-1:SET_W];
    assign take    = acc_valid && !clr;

    mc_tag_store #(.SET_W(SET_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .look_en(take), .look_set(set_idx), .look_tag(tag),
        .look_hit(hit)
    );

    mc_seen_map #(.BLK_W(BLK_W)) u_seen (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .mark_en(take), .blk(acc_blk), .seen(seen)
    );

    always_comb begin
        if (hit)       code = CLS_HIT;
        else if (seen) code = CLS_CONF;
        else           code = CLS_COMP;

        out_d.vld  = take;
        out_d.code = take ? code : CLS_HIT;

        inc_vec = '0;
        if (take) begin
            unique case (code)
                CLS_HIT:  inc_vec[0] = 1'b1;
                CLS_COMP: inc_vec[1] = 1'b1;
                default:  inc_vec[2] = 1'b1;
            endcase
        end
    end

    for (genvar g = 0; g < N_KIND; g++) begin : g_cnt
        mc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr(clr),
            .inc(inc_vec[g]), .cnt(cnt_arr[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{vld: 1'b0, code: CLS_HIT};
        else        out_q <= out_d;
    end

    assign cls_valid = out_q.vld;
    assign cls_code  = out_q.code;
    assign cnt_hit   = cnt_arr[0];
    assign cnt_comp  = cnt_arr[1];
    assign cnt_conf  = cnt_arr[2];

endmodule

// File: rtl/mc_checker.sv
module mc_checker #(
    parameter int BLK_W = 9,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             acc_valid,
    input logic [BLK_W-1:0] acc_blk,
    input logic             cls_valid,
    input logic [1:0]       cls_code,
    input logic [CNT_W-1:0] cnt_hit,
    input logic [CNT_W-1:0] cnt_comp,
    input logic [CNT_W-1:0] cnt_conf
);

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !clr) |=> cls_valid);

    assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !clr) |=> !cls_valid);

    assert_code_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cls_valid |-> (cls_code != 2'b11));

    assert_clear_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_hit == '0 && cnt_comp == '0 && cnt_conf == '0 && !cls_valid));

    assert_one_counter_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ($countones({cnt_hit != $past(cnt_hit),
                              cnt_comp != $past(cnt_comp),
                              cnt_conf != $past(cnt_conf)}) <= 1));

    assert_hit_ceiling_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt_hit == '1) |=> (cnt_hit == '1));

    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt_conf >= $past(cnt_conf) && cnt_comp >= $past(cnt_comp)));

    assert_repeat_is_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !clr && $past(acc_valid && !clr) && acc_blk == $past(acc_blk))
        |=> (cls_code == 2'b00));

endmodule

bind miss_classifier mc_checker #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .acc_valid(acc_valid), .acc_blk(acc_blk),
    .cls_valid(cls_valid), .cls_code(cls_code),
    .cnt_hit(cnt_hit), .cnt_comp(cnt_comp), .cnt_conf(cnt_conf)
);

// File: tb/sim_miss_classifier.sv
module sim_miss_classifier;
    localparam int CLK_PERIOD = 10;
    localparam int SETS = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        acc_valid = 1'b0;
    logic [8:0]  acc_blk = '0;
    logic        cls_valid;
    logic [1:0]  cls_code;
    logic [15:0] cnt_hit, cnt_comp, cnt_conf;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    bit m_vld [SETS][2];
    int m_tag [SETS][2];
    bit m_lru [SETS];
    bit m_seen [512];
    int e_hit, e_comp, e_conf;

    always #(CLK_PERIOD/2) clk = ~clk;

    miss_classifier u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .acc_valid(acc_valid), .acc_blk(acc_blk),
        .cls_valid(cls_valid), .cls_code(cls_code),
        .cnt_hit(cnt_hit), .cnt_comp(cnt_comp), .cnt_conf(cnt_conf)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < SETS; s++) begin
            m_vld[s][0] = 0; m_vld[s][1] = 0; m_lru[s] = 0;
        end
        for (int b = 0; b < 512; b++) m_seen[b] = 0;
        e_hit = 0; e_comp = 0; e_conf = 0;
    endtask

    // R2 split: set = low 7 bits, tag = upper 2 bits; R6 fill way 0 first, then LRU
    task automatic model_step(input int b, output int code);
        int s, t, w;
        s = b % SETS; t = b / SETS;
        if (m_vld[s][0] && m_tag[s][0] == t)      begin code = 0; m_lru[s] = 1; end
        else if (m_vld[s][1] && m_tag[s][1] == t) begin code = 0; m_lru[s] = 0; end
        else begin
            code = m_seen[b] ? 2 : 1;
            if (!m_vld[s][0])      w = 0;
            else if (!m_vld[s][1]) w = 1;
            else                   w = m_lru[s] ? 1 : 0;
            m_vld[s][w] = 1; m_tag[s][w] = t; m_lru[s] = (w == 0);
        end
        m_seen[b] = 1;
        if (code == 0 && e_hit < 65535) e_hit++;
        if (code == 1 && e_comp < 65535) e_comp++;
        if (code == 2 && e_conf < 65535) e_conf++;
    endtask

    task automatic access(input int b, input string req);
        int e;
        model_step(b, e);
        acc_valid = 1'b1; acc_blk = 9'(b);
        @(negedge clk);
        acc_valid = 1'b0;
        chk({req, " R7 valid"}, int'(cls_valid), 1);
        chk(req, int'(cls_code), e);
    endtask

    task automatic do_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        model_clear();
    endtask

    task automatic check_counts(input string req);
        chk({req, " hits"}, int'(cnt_hit), e_hit);
        chk({req, " compulsory"}, int'(cnt_comp), e_comp);
        chk({req, " conflict"}, int'(cnt_conf), e_conf);
    endtask

    task automatic finish_up();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            finish_up();
        end
    end

    initial begin
        int seq [16] = '{0,128,256,128,0,128,256,128,1,129,257,129,1,129,257,129};
        int lfsr;
        int e;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 reset valid", int'(cls_valid), 0);
        chk("R1 reset hits", int'(cnt_hit), 0);
        chk("R1 reset comp", int'(cnt_comp), 0);
        chk("R1 reset conf", int'(cnt_conf), 0);

        // R11 reference pattern, also R3 R4 R5 R6 per access
        for (int it = 0; it < 10; it++)
            for (int k = 0; k < 16; k++) access(seq[k], "R11 pattern code");
        chk("R11 hits", int'(cnt_hit), 78);
        chk("R11 compulsory", int'(cnt_comp), 6);
        chk("R11 conflict", int'(cnt_conf), 76);

        // R1 clear empties everything
        do_clear();
        chk("R1 clear valid", int'(cls_valid), 0);
        check_counts("R1 clear");
        access(0, "R1 first after clear compulsory");

        // R4 R5 R2 full sweeps: all first touches compulsory, revisits conflict
        do_clear();
        for (int b = 0; b < 512; b++) access(b, "R4 sweep first pass");
        chk("R4 sweep compulsory", int'(cnt_comp), 512);
        for (int b = 0; b < 512; b++) access(b, "R5 sweep second pass");
        chk("R5 sweep conflict", int'(cnt_conf), 512);
        chk("R2 sweep hits", int'(cnt_hit), 0);
        check_counts("R8 sweep");

        // R6 LRU ordering in set 5
        do_clear();
        access(5, "R6 fill way0");
        access(133, "R6 fill way1");
        access(5, "R3 hit refresh");
        access(261, "R6 evict lru");
        chk("R6 code after evict", int'(cls_code), 1);
        access(5, "R6 refreshed kept hit");
        chk("R6 kept resident", int'(cls_code), 0);
        access(133, "R5 evicted conflict");
        chk("R5 evicted code", int'(cls_code), 2);

        // R10 clear beats access
        do_clear();
        clr = 1'b1; acc_valid = 1'b1; acc_blk = 9'd7;
        @(negedge clk);
        clr = 1'b0; acc_valid = 1'b0;
        model_clear();
        chk("R10 no verdict", int'(cls_valid), 0);
        check_counts("R10 not counted");
        access(7, "R10 not recorded compulsory");

        // R9 saturation
        do_clear();
        access(3, "R9 first");
        acc_valid = 1'b1; acc_blk = 9'd3;
        repeat (65600) @(negedge clk);
        acc_valid = 1'b0;
        @(negedge clk);
        chk("R9 hit ceiling", int'(cnt_hit), 65535);
        chk("R9 comp untouched", int'(cnt_comp), 1);
        chk("R9 conf untouched", int'(cnt_conf), 0);

        // R3 R5 R6 R8 pseudo-random mix over four contended sets
        do_clear();
        lfsr = 32'h1ACE;
        for (int n = 0; n < 3000; n++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
            if ((lfsr & 8'h70) == 0) begin
                @(negedge clk);
                chk("R7 idle no valid", int'(cls_valid), 0);
            end else begin
                access(((lfsr & 3) << 7) | ((lfsr >> 2) & 3), "R6 mix code");
            end
        end
        check_counts("R8 mix totals");
        e = 0;

        done = 1;
        finish_up();
    end

endmodule